// File: doc/BRIEF.md
# Two-Street Traffic Light Sequencer

This block sequences the lamps at a crossing of a main street (A) and a side street (B). It runs on a slow clock, and each clock period stands for ten seconds of real time. A vehicle sensor on each street reports whether a car is present. The main street keeps green by default. It gives way only after a minimum green time, and only when a car is waiting on the side street. The side street then gets a fixed green time. That green time is stretched by one period when the side street is still occupied and the main street is empty. Control then goes back to the main street through a yellow phase.

The sequence lives in a binary-coded 4-bit state register with thirteen legal codes, 0 to 12. Codes 0 to 5 are main-street green, 6 is main-street yellow, 7 to 11 are side-street green and 12 is side-street yellow. A one-bit flag records whether the extension has been used in the current side-street cycle. All six lamp outputs are decoded from the state register alone, so a sensor change never reaches a lamp until the next clock edge. Codes 13 to 15 decode to red on both streets and lead to code 0 on the next clock.

Top module: `traffic_ctrl`

## Requirements
- R1: While `rst` is high, whatever the sensors do, the block shows green on A and red on B (state 0) after the next rising clock edge, and it leaves that state only on edges where `rst` is low.
- R2: From reset, A green lasts at least 6 clocks (60 s). The first five green states advance on every clock whatever the sensor values.
- R3: After the minimum, A stays green on every clock where `carOnB` is 0. On a clock where `carOnB` is 1, A turns yellow for the next period.
- R4: A yellow lasts exactly one clock. It is followed by red on A and green on B.
- R5: B green lasts 5 clocks (50 s). On its last clock, if `carOnA` is 1 or `carOnB` is 0, the next period shows yellow on B.
- R6: On the last B green clock, `carOnA` = 0 together with `carOnB` = 1 extends B green by exactly one clock (10 s). The extension is granted at most once per B cycle, so B green never exceeds 6 clocks.
- R7: B yellow lasts exactly one clock and is followed by green on A and red on B (state 0), which restarts the 6-clock minimum.
- R8: On every clock after reset exactly one lamp per street is lit, and a street's red lamp only comes on in the period right after its yellow lamp.
- R9: The lamp outputs depend only on the registered state. A change of `carOnA` or `carOnB` between clock edges leaves every lamp unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per 10 s |
| rst | input | 1 | Synchronous reset, active high |
| carOnA | input | 1 | Vehicle present on main street A |
| carOnB | input | 1 | Vehicle present on side street B |
| greenA | output | 1 | Green lamp, street A |
| yellowA | output | 1 | Yellow lamp, street A |
| redA | output | 1 | Red lamp, street A |
| greenB | output | 1 | Green lamp, street B |
| yellowB | output | 1 | Yellow lamp, street B |
| redB | output | 1 | Red lamp, street B |

## Verification
On the last side-street green clock, the extension request and the return to the main street are decided on the same edge. Which of the two wins depends on the sensor pair and on whether the extension flag is already set. The bench drives each sensor combination into that clock: both sensors high, both low, and the extension request held across the extended clock. It then compares the lamp pattern of the following period with the yellow-or-green outcome the requirements predict. A reset asserted in the middle of side-street green also checks that reset wins over normal sequencing on the same edge.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int A_MIN_CLKS   = 6;
  localparam int B_GREEN_CLKS = 5;
  localparam int NUM_STATES   = A_MIN_CLKS + B_GREEN_CLKS + 2;
  localparam int STATE_W      = $clog2(NUM_STATES);

  typedef logic [STATE_W-1:0] state_t;

  localparam state_t ST_A_FIRST = state_t'(0);
  localparam state_t ST_A_WAIT  = state_t'(A_MIN_CLKS - 1);
  localparam state_t ST_A_YEL   = state_t'(A_MIN_CLKS);
  localparam state_t ST_B_FIRST = state_t'(A_MIN_CLKS + 1);
  localparam state_t ST_B_LAST  = state_t'(A_MIN_CLKS + B_GREEN_CLKS);
  localparam state_t ST_B_YEL   = state_t'(A_MIN_CLKS + B_GREEN_CLKS + 1);

  typedef struct packed {
    state_t nextCode;
    logic   setExt;
    logic   clrExt;
  } ctrl_strobe_t;

  typedef struct packed {
    logic gA;
    logic yA;
    logic rA;
    logic gB;
    logic yB;
    logic rB;
  } lamps_t;
endpackage

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
(
  input  state_t       curState,
  input  logic         extUsed,
  input  logic         carOnA,
  input  logic         carOnB,
  output ctrl_strobe_t strobe
);
  logic wantExt;

  assign wantExt = !carOnA && carOnB && !extUsed;

  always_comb begin
    strobe          = '0;
    strobe.nextCode = ST_A_FIRST;
    if (curState < ST_A_WAIT) begin
      strobe.nextCode = curState + state_t'(1);
    end else if (curState == ST_A_WAIT) begin
      strobe.nextCode = carOnB ? ST_A_YEL : ST_A_WAIT;
    end else if (curState == ST_A_YEL) begin
      strobe.nextCode = ST_B_FIRST;
    end else if (curState < ST_B_LAST) begin
      strobe.nextCode = curState + state_t'(1);
    end else if (curState == ST_B_LAST) begin
      if (wantExt) begin
        strobe.nextCode = ST_B_LAST;
        strobe.setExt   = 1'b1;
      end else begin
        strobe.nextCode = ST_B_YEL;
      end
    end else begin
      // yellow B and every unused code lead back to the first A state
      strobe.nextCode = ST_A_FIRST;
      strobe.clrExt   = 1'b1;
    end
  end
endmodule

// File: rtl/tlc_path.sv
module tlc_path
  import tlc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrl_strobe_t strobe,
  output state_t       curState,
  output logic         extUsed,
  output lamps_t       lamps
);
  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_A_FIRST;
      extUsed  <= 1'b0;
    end else begin
      curState <= strobe.nextCode;
      if (strobe.setExt)
        extUsed <= 1'b1;
      else if (strobe.clrExt)
        extUsed <= 1'b0;
    end
  end

  always_comb begin
    lamps = '0;
    if (curState <= ST_A_WAIT) begin
      lamps.gA = 1'b1;
      lamps.rB = 1'b1;
    end else if (curState == ST_A_YEL) begin
      lamps.yA = 1'b1;
      lamps.rB = 1'b1;
    end else if (curState <= ST_B_LAST) begin
      lamps.rA = 1'b1;
      lamps.gB = 1'b1;
    end else if (curState == ST_B_YEL) begin
      lamps.rA = 1'b1;
      lamps.yB = 1'b1;
    end else begin
      lamps.rA = 1'b1;
      lamps.rB = 1'b1;
    end
  end
endmodule

// File: rtl/traffic_ctrl.sv
module traffic_ctrl
  import tlc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic carOnA,
  input  logic carOnB,
  output logic greenA,
  output logic yellowA,
  output logic redA,
  output logic greenB,
  output logic yellowB,
  output logic redB
);
  state_t       curState;
  logic         extUsed;
  ctrl_strobe_t strobe;
  lamps_t       lamps;

  tlc_ctrl u_ctrl (
    .curState (curState),
    .extUsed  (extUsed),
    .carOnA   (carOnA),
    .carOnB   (carOnB),
    .strobe   (strobe)
  );

  tlc_path u_path (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curState (curState),
    .extUsed  (extUsed),
    .lamps    (lamps)
  );

  assign greenA  = lamps.gA;
  assign yellowA = lamps.yA;
  assign redA    = lamps.rA;
  assign greenB  = lamps.gB;
  assign yellowB = lamps.yB;
  assign redB    = lamps.rB;
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker
  import tlc_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic carOnA,
  input logic carOnB,
  input logic greenA,
  input logic yellowA,
  input logic redA,
  input logic greenB,
  input logic yellowB,
  input logic redB
);
  logic [3:0] aRun;
  logic [3:0] bRun;
  logic       seenEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      aRun     <= '0;
      bRun     <= '0;
      seenEdge <= 1'b0;
    end else begin
      seenEdge <= 1'b1;
      if (redA) aRun <= '0;
      else if (greenA && aRun != 4'hF) aRun <= aRun + 4'd1;
      if (redB) bRun <= '0;
      else if (greenB && bRun != 4'hF) bRun <= bRun + 4'd1;
    end
  end

  // R8
  one_lamp_a_chk: assert property (@(posedge clk) disable iff (rst)
    seenEdge |-> $countones({greenA, yellowA, redA}) == 1);
  // R8
  one_lamp_b_chk: assert property (@(posedge clk) disable iff (rst)
    seenEdge |-> $countones({greenB, yellowB, redB}) == 1);
  // R8
  red_a_after_yel_chk: assert property (@(posedge clk) disable iff (rst)
    (seenEdge && $rose(redA)) |-> $past(yellowA));
  // R8
  red_b_after_yel_chk: assert property (@(posedge clk) disable iff (rst)
    (seenEdge && $rose(redB)) |-> $past(yellowB));
  // R2
  a_min_green_chk: assert property (@(posedge clk) disable iff (rst)
    yellowA |-> aRun >= 4'(A_MIN_CLKS));
  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (greenA && !carOnB) |=> greenA);
  // R4
  a_yel_one_chk: assert property (@(posedge clk) disable iff (rst)
    yellowA |=> greenB);
  // R5
  b_min_green_chk: assert property (@(posedge clk) disable iff (rst)
    yellowB |-> bRun >= 4'(B_GREEN_CLKS));
  // R6
  b_max_green_chk: assert property (@(posedge clk) disable iff (rst)
    greenB |-> bRun <= 4'(B_GREEN_CLKS));
  // R7
  b_yel_one_chk: assert property (@(posedge clk) disable iff (rst)
    yellowB |=> greenA);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (greenA && redB));
endmodule

bind traffic_ctrl tlc_checker u_tlc_checker (
  .clk     (clk),
  .rst     (rst),
  .carOnA  (carOnA),
  .carOnB  (carOnB),
  .greenA  (greenA),
  .yellowA (yellowA),
  .redA    (redA),
  .greenB  (greenB),
  .yellowB (yellowB),
  .redB    (redB)
);

// File: tb/tb_traffic_ctrl.sv
`timescale 1ns/1ps
module tb_traffic_ctrl;
  localparam logic [5:0] GARB = 6'b100_001;
  localparam logic [5:0] YARB = 6'b010_001;
  localparam logic [5:0] RAGB = 6'b001_100;
  localparam logic [5:0] RAYB = 6'b001_010;

  logic clk = 1'b0;
  logic rst, carOnA, carOnB;
  logic greenA, yellowA, redA, greenB, yellowB, redB;
  logic [5:0] lampVec;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  logic [5:0] curExp;

  typedef struct {
    int         due;
    logic [5:0] val;
    string      tag;
  } exp_item_t;
  exp_item_t expQ[$];

  traffic_ctrl dut (
    .clk(clk), .rst(rst), .carOnA(carOnA), .carOnB(carOnB),
    .greenA(greenA), .yellowA(yellowA), .redA(redA),
    .greenB(greenB), .yellowB(yellowB), .redB(redB)
  );

  assign lampVec = {greenA, yellowA, redA, greenB, yellowB, redB};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag,
                     input logic [5:0] act, input logic [5:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // driver: called at a falling edge; sets inputs, confirms R9, queues result
  task automatic step(input logic r, input logic a, input logic b,
                      input logic [5:0] exp, input string tag);
    rst    = r;
    carOnA = a;
    carOnB = b;
    #1;
    chk(lampVec == curExp, "R9 lamps moved between edges", lampVec, curExp);
    expQ.push_back('{due: cyc + 1, val: exp, tag: tag});
    curExp = exp;
    @(negedge clk);
  endtask

  // monitor: pops the item due in this cycle
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      exp_item_t it;
      it = expQ.pop_front();
      chk(lampVec == it.val, it.tag, lampVec, it.val);
      chk(($countones(lampVec[5:3]) == 1) && ($countones(lampVec[2:0]) == 1),
          "R8 one lamp per street", lampVec, it.val);
    end
  end

  initial begin
    #2_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst = 1'b1; carOnA = 1'b0; carOnB = 1'b0;
    repeat (3) @(negedge clk);
    chk(lampVec == GARB, "R1 reset state", lampVec, GARB);
    carOnA = 1'b1; carOnB = 1'b1;
    @(negedge clk);
    chk(lampVec == GARB, "R1 sensors ignored in reset", lampVec, GARB);
    curExp = GARB;

    // Pattern 1: B always occupied, A empty -> extension taken once
    for (int i = 0; i < 5; i++) step(0, 0, 1, GARB, "R2 unconditional A green");
    step(0, 0, 1, YARB, "R3 yellow A after minimum");
    step(0, 0, 1, RAGB, "R4 one yellow then B green");
    for (int i = 0; i < 4; i++) step(0, 0, 1, RAGB, "R5 B green run");
    step(0, 0, 1, RAGB, "R6 extension granted");
    step(0, 0, 1, RAYB, "R6 extension only once");
    step(0, 0, 1, GARB, "R7 back to A green");

    // Pattern 2: B empty holds A green; both sensors at B end -> no extension
    for (int i = 0; i < 5; i++) step(0, 1, 0, GARB, "R2 A minimum with B empty");
    for (int i = 0; i < 3; i++) step(0, 1, 0, GARB, "R3 A holds while B empty");
    step(0, 0, 1, YARB, "R3 B car turns A yellow");
    step(0, 1, 0, RAGB, "R4 B green follows");
    for (int i = 0; i < 4; i++) step(0, 0, 1, RAGB, "R5 B green run");
    step(0, 1, 1, RAYB, "R5 car on A ends B green");
    step(0, 0, 0, GARB, "R7 A green again");

    // Pattern 3: both empty at B end; minimum restarts after R7
    for (int i = 0; i < 5; i++) step(0, 0, 1, GARB, "R7 minimum restarts");
    step(0, 0, 1, YARB, "R3 yellow A");
    for (int i = 0; i < 5; i++) step(0, 0, 0, RAGB, "R5 B green run");
    step(0, 0, 0, RAYB, "R5 B empty ends B green");
    step(0, 0, 0, GARB, "R7 A green");

    // Pattern 4: extension then A car arrives during extended clock
    for (int i = 0; i < 5; i++) step(0, 0, 1, GARB, "R2 minimum");
    step(0, 0, 1, YARB, "R3 yellow A");
    for (int i = 0; i < 5; i++) step(0, 0, 1, RAGB, "R5 B green run");
    step(0, 0, 1, RAGB, "R6 extension granted again in new cycle");
    step(0, 1, 1, RAYB, "R6 extended clock ends");
    step(0, 0, 0, GARB, "R7 A green");

    // Pattern 5: reset in the middle of B green
    for (int i = 0; i < 5; i++) step(0, 0, 1, GARB, "R2 minimum");
    step(0, 0, 1, YARB, "R3 yellow A");
    step(0, 0, 1, RAGB, "R4 B green");
    step(0, 0, 1, RAGB, "R5 B green run");
    step(1, 0, 1, GARB, "R1 reset overrides B green");
    step(0, 0, 1, GARB, "R1 first clock after reset");
    for (int i = 0; i < 4; i++) step(0, 0, 1, GARB, "R2 minimum after reset");
    step(0, 0, 1, YARB, "R3 yellow A after reset");

    @(negedge clk);
    summary();
  end
endmodule